// File: doc/BRIEF.md
# Servo Position Pulse Generator

This block drives one hobby-servo control line from the system clock. A prescaler turns the clock into a slower count tick, and a frame counter repeats every fixed number of ticks, which sets a frame rate near 50 Hz. Each frame begins with the output high. The output stays high for a programmed number of ticks and is then low until the frame ends. The servo reads the length of the high pulse as a target angle.

The position is given as an unsigned 8-bit command with a load strobe. The command maps linearly onto the calibrated pulse range of the servo. Command 0 gives the counter-clockwise limit and command 255 gives the clockwise limit. The computed width is clamped to those two limits. A loaded command is held in a shadow register and reaches the output only at the next frame boundary, so a pulse is never cut short or stretched in the middle.

The servo calibration is set by parameters: the counter-clockwise width, the clockwise width and the reset-time center width, all counted in ticks. With the defaults, the 50 MHz clock is divided by 50, a frame is 20000 ticks, and the three widths are 840, 1960 and 1400 ticks. These are 4.2 %, 9.8 % and 7.0 % duty at 50 Hz. A servo with a different profile, for example 3.2 % / 9.8 % with a 5.6 % center, only needs other parameter values.

Top module: `servo_pwm`

## Requirements
- R1: The output repeats with a period of exactly FRAME_COUNTS × PRESCALE clock cycles, measured from one rising edge to the next.
- R2: In every frame the output is high for a single run of width × PRESCALE clock cycles, starting at the frame start. It is low for the rest of the frame.
- R3: The output is low while reset is asserted. The first frame after reset uses CENTER_COUNTS as its width.
- R4: A loaded command c gives the width CCW_COUNTS + floor((CW_COUNTS − CCW_COUNTS) × c / 255). Command 0 gives CCW_COUNTS and command 255 gives CW_COUNTS.
- R5: The width in use never falls below CCW_COUNTS and never rises above CW_COUNTS.
- R6: A load made during a frame leaves the pulse of that frame unchanged. The new width applies from the next frame.
- R7: A load made in the last clock cycle of a frame applies to the frame that begins at the next edge.
- R8: If several loads happen in one frame, the last one decides the width of the next frame.
- R9: Without a load, the width stays the same from frame to frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| posCmd | input | 8 | Position command, 0 = counter-clockwise limit, 255 = clockwise limit |
| loadStb | input | 1 | Loads posCmd into the shadow register for this cycle |
| pwmOut | output | 1 | Servo control pulse |

## Verification
Two events can fall in the same cycle: a command load and the frame-boundary update of the active width. When both occur, the loaded value must skip the shadow register and go straight into the frame that is starting. The bench provokes this by counting clock cycles from an observed rising edge. It places the load strobe exactly in the final cycle of a frame, and also well inside a frame. For each case the scoreboard expects the new width in the pulse that follows. If the same-cycle load were lost or delayed by a frame, that pulse would come out with the old width and the check would fail.

// File: rtl/servo_pwm_pkg.sv
package servo_pwm_pkg;

  // Strobes sent from the timing control to the pulse datapath
  typedef struct packed {
    logic tick;        // one prescaled count step
    logic frameStart;  // last cycle of a frame; the counter wraps at the next edge
  } pwmStrobes_t;

endpackage

// File: rtl/servo_pwm_ctrl.sv
module servo_pwm_ctrl
  import servo_pwm_pkg::*;
#(
  parameter int PRESCALE     = 50,
  parameter int FRAME_COUNTS = 20000,
  parameter int CNT_W        = 15
) (
  input  logic             clk,
  input  logic             rstN,
  output pwmStrobes_t      strobes,
  output logic [CNT_W-1:0] frameCnt
);

  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_COUNTS - 1);

  logic tick;

  generate
    if (PRESCALE > 1) begin : g_prescale
      logic [PRE_W-1:0] preCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)      preCnt <= '0;
        else if (tick)  preCnt <= '0;
        else            preCnt <= preCnt + 1'b1;
      end
      assign tick = (preCnt == PRE_W'(PRESCALE - 1));
    end else begin : g_direct
      assign tick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  frameCnt <= '0;
    else if (strobes.frameStart) frameCnt <= '0;
    else if (tick)              frameCnt <= frameCnt + 1'b1;
  end

  always_comb begin
    strobes.tick       = tick;
    strobes.frameStart = tick && (frameCnt == LAST_CNT);
  end

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameCnt <= LAST_CNT);

  // R1
  frame_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.frameStart |=> (frameCnt == '0));

endmodule

// File: rtl/servo_pwm_dp.sv
module servo_pwm_dp
  import servo_pwm_pkg::*;
#(
  parameter int CNT_W         = 15,
  parameter int CCW_COUNTS    = 840,
  parameter int CW_COUNTS     = 1960,
  parameter int CENTER_COUNTS = 1400
) (
  input  logic             clk,
  input  logic             rstN,
  input  pwmStrobes_t      strobes,
  input  logic [CNT_W-1:0] frameCnt,
  input  logic             loadStb,
  input  logic [7:0]       posCmd,
  output logic             pwmOut
);

  localparam int SPAN   = CW_COUNTS - CCW_COUNTS;
  localparam int PROD_W = CNT_W + 8;
  localparam logic [CNT_W-1:0] MIN_W = CNT_W'(CCW_COUNTS);
  localparam logic [CNT_W-1:0] MAX_W = CNT_W'(CW_COUNTS);
  localparam logic [CNT_W-1:0] MID_W = CNT_W'(CENTER_COUNTS);

  logic [PROD_W-1:0] scaled, quot;
  logic [CNT_W-1:0]  mapped, clamped;
  logic [CNT_W-1:0]  shadowWidth, activeWidth;
  logic              pwmQ;

  // Linear map of the command onto the calibrated range, then clamp
  always_comb begin
    scaled = PROD_W'(SPAN) * PROD_W'(posCmd);
    quot   = scaled / PROD_W'(255);
    mapped = MIN_W + CNT_W'(quot);
    if (mapped < MIN_W)      clamped = MIN_W;
    else if (mapped > MAX_W) clamped = MAX_W;
    else                     clamped = mapped;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        shadowWidth <= MID_W;
    else if (loadStb) shadowWidth <= clamped;
  end

  // Width changes only at a frame boundary; a load in that same cycle is used directly
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   activeWidth <= MID_W;
    else if (strobes.frameStart) activeWidth <= loadStb ? clamped : shadowWidth;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pwmQ <= 1'b0;
    else       pwmQ <= (frameCnt < activeWidth);
  end

  assign pwmOut = pwmQ;

  // R1
  start_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.frameStart |-> strobes.tick);

  // R6
  width_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.frameStart |=> $stable(activeWidth));

  // R5
  width_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (activeWidth >= MIN_W) && (activeWidth <= MAX_W));

  // R9
  shadow_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    !loadStb |=> $stable(shadowWidth));

  // R4
  ccw_map_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb && posCmd == 8'd0) |=> (shadowWidth == MIN_W));

  // R4
  cw_map_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb && posCmd == 8'd255) |=> (shadowWidth == MAX_W));

endmodule

// File: rtl/servo_pwm.sv
module servo_pwm
  import servo_pwm_pkg::*;
#(
  parameter int PRESCALE      = 50,
  parameter int FRAME_COUNTS  = 20000,
  parameter int CCW_COUNTS    = 840,
  parameter int CW_COUNTS     = 1960,
  parameter int CENTER_COUNTS = 1400
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] posCmd,
  input  logic       loadStb,
  output logic       pwmOut
);

  localparam int CNT_W = $clog2(FRAME_COUNTS + 1);

  pwmStrobes_t      strobes;
  logic [CNT_W-1:0] frameCnt;

  servo_pwm_ctrl #(
    .PRESCALE     (PRESCALE),
    .FRAME_COUNTS (FRAME_COUNTS),
    .CNT_W        (CNT_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .frameCnt (frameCnt)
  );

  servo_pwm_dp #(
    .CNT_W         (CNT_W),
    .CCW_COUNTS    (CCW_COUNTS),
    .CW_COUNTS     (CW_COUNTS),
    .CENTER_COUNTS (CENTER_COUNTS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .frameCnt (frameCnt),
    .loadStb  (loadStb),
    .posCmd   (posCmd),
    .pwmOut   (pwmOut)
  );

endmodule

// File: tb/servo_pwm_bench.sv
`timescale 1ns/1ps
module servo_pwm_bench;

  localparam int PRE = 2;
  localparam int FRM = 100;
  localparam int CCW = 10;
  localparam int CW  = 40;
  localparam int MID = 25;
  localparam int PERIOD = PRE * FRM;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] posCmd = 8'd0;
  logic       loadStb = 1'b0;
  logic       pwmOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct { int cycles; string tag; } expItem_t;
  expItem_t expQ[$];

  always #5 clk = ~clk;

  servo_pwm #(
    .PRESCALE(PRE), .FRAME_COUNTS(FRM),
    .CCW_COUNTS(CCW), .CW_COUNTS(CW), .CENTER_COUNTS(MID)
  ) u_servo_pwm (
    .clk(clk), .rstN(rstN), .posCmd(posCmd), .loadStb(loadStb), .pwmOut(pwmOut)
  );

  function automatic int mapCmd(int c);
    return CCW + ((CW - CCW) * c) / 255;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pushExp(int widthCounts, string tag);
    expItem_t it;
    it.cycles = widthCounts * PRE;
    it.tag = tag;
    expQ.push_back(it);
  endtask

  // Align to the negedge right after a rising edge of the output
  task automatic syncRise();
    @(posedge pwmOut);
    @(negedge clk);
  endtask

  // Load that is sampled k edges after the observed rising edge
  task automatic doLoad(int cmd, int k);
    repeat (k - 1) @(negedge clk);
    posCmd  = 8'(cmd);
    loadStb = 1'b1;
    @(negedge clk);
    loadStb = 1'b0;
  endtask

  // Monitor: measure each pulse and each period, compare against the queue
  int  highCnt = 0;
  int  sinceRise = 0;
  bit  seenRise = 1'b0;
  logic prevPwm = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (pwmOut) highCnt++;
      if (pwmOut && !prevPwm) begin
        // R1 period
        if (seenRise) check(sinceRise == PERIOD, "R1 period", sinceRise, PERIOD);
        seenRise = 1'b1;
        sinceRise = 0;
      end
      sinceRise++;
      if (!pwmOut && prevPwm) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R2 unexpected pulse", highCnt, 0);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          check(highCnt == it.cycles, it.tag, highCnt, it.cycles);
        end
        highCnt = 0;
      end
      prevPwm = pwmOut;
    end
  end

  initial begin
    int last;
    repeat (4) @(negedge clk);
    check(pwmOut == 1'b0, "R3 low in reset", int'(pwmOut), 0);
    pushExp(MID, "R3 first frame center");
    last = MID;
    rstN = 1'b1;

    syncRise();                       // frame 1
    doLoad(128, 50);
    pushExp(mapCmd(128), "R6 mid-frame load deferred");
    last = mapCmd(128);

    syncRise();                       // frame 2
    doLoad(0, 10);
    pushExp(mapCmd(0), "R4 R5 cmd 0 ccw limit");
    last = mapCmd(0);

    syncRise();                       // frame 3
    doLoad(255, PERIOD - 1);          // last cycle of the frame
    pushExp(mapCmd(255), "R7 boundary load cmd 255");
    last = mapCmd(255);

    syncRise();                       // frame 4
    pushExp(last, "R9 width kept without load");

    syncRise();                       // frame 5
    doLoad(85, 20);
    doLoad(254, 130);
    pushExp(mapCmd(254), "R8 last load wins");
    last = mapCmd(254);

    syncRise();                       // frame 6
    doLoad(1, 1);
    pushExp(mapCmd(1), "R4 cmd 1 early load");
    last = mapCmd(1);

    syncRise();                       // frame 7
    doLoad(200, PERIOD - 1);
    pushExp(mapCmd(200), "R7 boundary load cmd 200");
    last = mapCmd(200);

    syncRise();                       // frame 8
    @(negedge pwmOut);
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R2 all pulses seen", expQ.size(), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule